// File: doc/BRIEF.md
# Receive Byte Queue with Occupancy and Error Status

This block sits between a serial deserializer and a register-read port. Bytes arriving from the line are stored in order and handed out one per read strobe. With queue mode on, storage is a circular buffer addressed by a store pointer and a retrieve pointer, 16 entries by default. With queue mode off, it shrinks to a single holding register that each new byte overwrites.

Beside the data path it keeps a status word holding the occupancy count and a full flag, a data-ready flag, a four-bit error status, and a sticky receive-error interrupt source. A line break counts as a received zero byte and is recorded in the error status. Reading the error status returns it and empties it. A flush strobe puts both pointers back to zero. Parity and framing checks are not part of this block; their error bits stay zero.

Top module: `rxq_buffer`

## Requirements
- R1: After reset, rx_byte, stat_word, err_word, data_ready and err_irq are all zero.
- R2: With queue mode on, bytes come out on rx_byte in arrival order, one per rd_data strobe, valid from the clock edge that samples the strobe. This holds across pointer wrap-around.
- R3: stat_word[7:0] is the occupancy and stat_word[8] is the full flag. When the queue holds DEPTH entries, bit 8 is 1 and bits [7:0] read 0. The word reflects every store and read from the edge that samples them.
- R4: A byte that arrives while the queue is full, with no read in the same cycle, is discarded. Error status bit 0 (overrun) is set and err_irq rises. data_ready stays 1.
- R5: A read strobe with queue mode on and the queue empty returns 0 on rx_byte, raises err_irq and leaves the occupancy at 0.
- R6: With queue mode on, data_ready is 1 exactly when the occupancy is non-zero. It therefore clears on the read that empties the queue and stays set after any other read.
- R7: line_brk is taken as the arrival of byte 0x00; line_valid in the same cycle is ignored. It also sets error status bit 3 (break).
- R8: An rd_err strobe puts the error status (bit 0 overrun, bit 1 parity, bit 2 frame, bit 3 break) on err_word and clears it. A new error in that same cycle is kept for the next read.
- R9: A flush strobe zeroes both pointers, so occupancy and data_ready become 0. Stores and reads in the flush cycle are discarded.
- R10: With queue mode off, each arriving byte overwrites the holding register and sets data_ready. A read returns the holding register and clears data_ready. The queue contents and its occupancy are left untouched.
- R11: A store and a read in the same cycle are both accepted, even when the queue is full. The occupancy stays the same and the read returns the oldest byte.
- R12: err_irq stays set until an irq_clr strobe. A new error in the clear cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_on | input | 1 | 1 selects queue mode, 0 selects the single holding register |
| flush | input | 1 | Self-clearing strobe that resets the queue pointers |
| line_valid | input | 1 | A received byte is present on line_data |
| line_data | input | 8 | Received byte |
| line_brk | input | 1 | Break seen on the line |
| rd_data | input | 1 | Read strobe for the received-data register |
| rd_err | input | 1 | Read strobe for the error status |
| irq_clr | input | 1 | Clears the error interrupt source |
| rx_byte | output | 8 | Byte returned by the last data read |
| err_word | output | 4 | Error status returned by the last rd_err |
| stat_word | output | 9 | Full flag in bit 8, occupancy in bits [7:0] |
| data_ready | output | 1 | Received data is available |
| err_irq | output | 1 | Sticky receive-error interrupt source |

## Verification
Every result is registered, and all of them (rx_byte, err_word, stat_word, data_ready and err_irq) take their new value at the first rising edge that samples the stimulus. The bench drives inputs 2 ns after a rising edge, waits for the next edge, and reads outputs 2 ns later, so each check sees exactly one edge's worth of effect. The bench keeps its own model of the queue as an array with head and tail indices. It sweeps the occupancy through every value from 0 to full and pushes bytes through every pointer position with wrap-around.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // error status bit positions
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;
  localparam int ERR_W   = 4;
  // status word layout
  localparam int STAT_CNT_W = 8;
  localparam int STAT_FULL  = 8;
  localparam int STAT_W     = 9;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_byte,
  input  logic          pop,
  output logic [W-1:0]  pop_byte,
  output logic [CW-1:0] level
);
  // pointers carry one extra wrap bit so full and empty differ
  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   sp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[sp[AW-1:0]] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) pop_byte <= '0;
    else if (pop) pop_byte <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sp <= '0;
      rp <= '0;
    end else begin
      if (push) sp <= sp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign level = sp - rp;
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         take,
  output logic [W-1:0] hold_byte,
  output logic         hold_rdy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte <= '0;
      hold_rdy  <= 1'b0;
    end else begin
      if (load) hold_byte <= load_byte;
      if (load) hold_rdy <= 1'b1;
      else if (take) hold_rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_on,
  input  logic                flush,
  input  logic                line_valid,
  input  logic [W-1:0]        line_data,
  input  logic                line_brk,
  input  logic                rd_data,
  input  logic                rd_err,
  input  logic                irq_clr,
  output logic [W-1:0]        rx_byte,
  output logic [ERR_W-1:0]    err_word,
  output logic [STAT_W-1:0]   stat_word,
  output logic                data_ready,
  output logic                err_irq
);
  logic [CW-1:0]    level, lvl_nxt;
  logic             full, empty, arrive;
  logic [W-1:0]     abyte, ring_byte, hold_byte;
  logic             pop_ok, push_ok, ovr, under;
  logic             hold_rdy, fifo_rdy_q, mode_q, src_ring_q;
  logic [W-1:0]     side_q;
  logic [ERR_W-1:0] err_q, err_set;

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign arrive = line_brk | line_valid;
  assign abyte  = line_brk ? '0 : line_data;

  assign pop_ok  = fifo_on & rd_data & ~flush & ~empty;
  assign push_ok = fifo_on & arrive & ~flush & (~full | pop_ok);
  assign ovr     = fifo_on & arrive & ~flush & full & ~pop_ok;
  assign under   = fifo_on & rd_data & ~flush & empty;

  always_comb begin
    if (flush) lvl_nxt = '0;
    else       lvl_nxt = level + CW'(push_ok) - CW'(pop_ok);
  end

  rxq_ring #(.DEPTH(DEPTH), .W(W)) u_ring (
    .clk(clk), .rst(rst), .flush(flush),
    .push(push_ok), .push_byte(abyte),
    .pop(pop_ok), .pop_byte(ring_byte),
    .level(level)
  );

  rxq_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst),
    .load(~fifo_on & arrive), .load_byte(abyte),
    .take(~fifo_on & rd_data),
    .hold_byte(hold_byte), .hold_rdy(hold_rdy)
  );

  // read data source: ring output register, or a captured side value
  always_ff @(posedge clk) begin
    if (rst) begin
      src_ring_q <= 1'b0;
      side_q     <= '0;
    end else if (rd_data) begin
      src_ring_q <= pop_ok;
      side_q     <= fifo_on ? '0 : hold_byte;
    end
  end
  assign rx_byte = src_ring_q ? ring_byte : side_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_word  <= '0;
      fifo_rdy_q <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      stat_word[STAT_FULL] <= (lvl_nxt == CW'(DEPTH));
      stat_word[STAT_CNT_W-1:0] <= (lvl_nxt == CW'(DEPTH)) ? '0 : STAT_CNT_W'(lvl_nxt);
      fifo_rdy_q <= (lvl_nxt != '0);
      mode_q     <= fifo_on;
    end
  end
  assign data_ready = mode_q ? fifo_rdy_q : hold_rdy;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = ovr;
    err_set[ERR_BRK] = line_brk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= '0;
      err_word <= '0;
      err_irq  <= 1'b0;
    end else begin
      err_q   <= (rd_err ? '0 : err_q) | err_set;
      if (rd_err) err_word <= err_q;
      err_irq <= (err_irq & ~irq_clr) | ovr | under;
    end
  end
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk (
  input logic       clk,
  input logic       rst,
  input logic       fifo_on,
  input logic       flush,
  input logic       line_valid,
  input logic       line_brk,
  input logic       rd_data,
  input logic       rd_err,
  input logic       irq_clr,
  input logic [7:0] rx_byte,
  input logic [3:0] err_word,
  input logic [8:0] stat_word,
  input logic       data_ready,
  input logic       err_irq,
  input logic [3:0] err_q
);
  a_r3_full_zero_count: assert property (@(posedge clk) disable iff (rst)
    stat_word[8] |-> stat_word[7:0] == 8'd0);

  a_r6_ready_tracks_count: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_on) |-> data_ready == (stat_word != 9'd0));

  a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && rd_data && !flush && stat_word == 9'd0) |=> (err_irq && rx_byte == 8'd0));

  a_r7_break_flag: assert property (@(posedge clk) disable iff (rst)
    line_brk |=> err_q[3]);

  a_r8_err_read: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> err_word == $past(err_q));

  a_r11_both_accepted: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && !flush && rd_data && (line_valid || line_brk) && stat_word != 9'd0)
      |=> $stable(stat_word));

  a_r12_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_irq && !irq_clr) |=> err_irq);
endmodule

bind rxq_buffer rxq_buffer_chk u_chk (
  .clk(clk), .rst(rst), .fifo_on(fifo_on), .flush(flush),
  .line_valid(line_valid), .line_brk(line_brk), .rd_data(rd_data),
  .rd_err(rd_err), .irq_clr(irq_clr), .rx_byte(rx_byte),
  .err_word(err_word), .stat_word(stat_word), .data_ready(data_ready),
  .err_irq(err_irq), .err_q(err_q)
);

// File: tb/test_rxq_buffer.sv
`timescale 1ns/1ps
module test_rxq_buffer;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic fifo_on = 1'b1, flush = 1'b0, line_valid = 1'b0, line_brk = 1'b0;
  logic rd_data = 1'b0, rd_err = 1'b0, irq_clr = 1'b0;
  logic [7:0] line_data = '0;
  logic [7:0] rx_byte;
  logic [3:0] err_word;
  logic [8:0] stat_word;
  logic data_ready, err_irq;
  int checks = 0, failures = 0;
  logic done = 1'b0;
  logic [7:0] mq [64];
  int head = 0, tail = 0;

  always #10 clk = ~clk;

  rxq_buffer #(.DEPTH(DEPTH)) i_rxq_buffer (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .flush(flush),
    .line_valid(line_valid), .line_data(line_data), .line_brk(line_brk),
    .rd_data(rd_data), .rd_err(rd_err), .irq_clr(irq_clr),
    .rx_byte(rx_byte), .err_word(err_word), .stat_word(stat_word),
    .data_ready(data_ready), .err_irq(err_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
    line_valid = 0; line_brk = 0; rd_data = 0; rd_err = 0; irq_clr = 0; flush = 0;
  endtask

  function automatic int stat_of(input int n);
    return (n == DEPTH) ? 9'h100 : n;
  endfunction

  task automatic push(input logic [7:0] b);
    line_valid = 1; line_data = b; tick();
  endtask

  task automatic pop;
    rd_data = 1; tick();
  endtask

  task automatic read_err(input string req, input int exp);
    rd_err = 1; tick();
    chk(req, err_word, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 stat", stat_word, 0);
    chk("R1 err", err_word, 0);
    chk("R1 ready", data_ready, 0);
    chk("R1 irq", err_irq, 0);

    // R3 sweep of occupancy from 1 to full
    for (int i = 1; i <= DEPTH; i++) begin
      mq[tail % 64] = 8'(i * 13 + 5); push(mq[tail % 64]); tail++;
      chk("R3 count", stat_word, stat_of(tail - head));
      chk("R6 ready on fill", data_ready, 1);
    end
    // R4 overrun
    push(8'hEE);
    chk("R4 stat full", stat_word, 9'h100);
    chk("R4 irq", err_irq, 1);
    chk("R4 ready", data_ready, 1);
    read_err("R8 overrun bit", 4'b0001);
    read_err("R8 cleared", 4'b0000);
    // R11 simultaneous at full
    rd_data = 1; line_valid = 1; line_data = 8'hA7; tick();
    chk("R11 read data", rx_byte, mq[head % 64]); head++;
    mq[tail % 64] = 8'hA7; tail++;
    chk("R11 stat", stat_word, 9'h100);
    // R2 drain
    while (head != tail) begin
      pop();
      chk("R2 order", rx_byte, mq[head % 64]); head++;
      chk("R3 count drain", stat_word, stat_of(tail - head));
      chk("R6 ready drain", data_ready, (tail != head) ? 1 : 0);
    end
    // R12 clear, then R5 empty read
    irq_clr = 1; tick();
    chk("R12 cleared", err_irq, 0);
    pop();
    chk("R5 data", rx_byte, 0);
    chk("R5 irq", err_irq, 1);
    chk("R5 stat", stat_word, 0);
    irq_clr = 1; rd_data = 1; tick();
    chk("R12 set wins", err_irq, 1);
    irq_clr = 1; tick();
    chk("R12 clear", err_irq, 0);
    // R7 break
    line_brk = 1; line_valid = 1; line_data = 8'h55; tick();
    chk("R7 stat", stat_word, 1);
    read_err("R7 break bit", 4'b1000);
    pop();
    chk("R7 zero byte", rx_byte, 0);
    chk("R7 now empty", stat_word, 0);
    // R9 flush
    push(8'h11); push(8'h22); push(8'h33);
    flush = 1; line_valid = 1; line_data = 8'h44; rd_data = 1; tick();
    chk("R9 stat", stat_word, 0);
    chk("R9 ready", data_ready, 0);
    push(8'h66); pop();
    chk("R9 fresh after flush", rx_byte, 8'h66);
    // R2 wrap sweep, with R11 at partial occupancy
    push(8'h80);
    for (int k = 0; k < 40; k++) begin
      rd_data = 1; line_valid = 1; line_data = 8'(k + 8'h81); tick();
      chk("R2 wrap order", rx_byte, (k == 0) ? 8'h80 : 8'(k + 8'h80));
      chk("R11 stat stable", stat_word, 1);
    end
    pop();
    chk("R2 wrap last", rx_byte, 8'(39 + 8'h81));
    // R10 holding register mode
    push(8'hC1); push(8'hC2);
    fifo_on = 0;
    push(8'hD1); push(8'hD2);
    chk("R10 ready", data_ready, 1);
    chk("R10 stat untouched", stat_word, 2);
    pop();
    chk("R10 latest byte", rx_byte, 8'hD2);
    chk("R10 ready cleared", data_ready, 0);
    fifo_on = 1; pop();
    chk("R10 queue kept", rx_byte, 8'hC1);
    chk("R10 count", stat_word, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule